// File: doc/BRIEF.md
# ECP-style port FIFO controller

This block is the byte-wide FIFO and extended control register behind an extended-capabilities parallel port. The host reaches it through a small register window. A two-bit select picks the data FIFO, a read-only configuration word or the extended control register. Separate write and read strobes act on the selected register. A direction input tells the block which way data would move on the cable.

The control register carries a three-bit operating mode, a fault-interrupt disable bit, a DMA enable bit and a service bit. The lowest two bits report FIFO full and FIFO empty, and are read-only. In test mode the host can push bytes into the FIFO and pop them back out, which lets software measure the fill and drain thresholds. The service bit is set by hardware once the FIFO level crosses the threshold for the current direction, and the interrupt output follows it. Selecting the standard or byte mode empties the FIFO.

Top module: `pfq_ctrl`

## Requirements
- R1: After reset the control register reads 0x15 (mode 000, fault-interrupt disable 1, DMA 0, service 1, empty 1), the FIFO is empty and `irq_o` is low.
- R2: Select code 2'b10 addresses the control register. A write stores bits 7:2: mode in 7:5, fault-interrupt disable in 4, DMA enable in 3, service in 2. A read returns those bits with full in bit 1 and empty in bit 0. Select 2'b11 reads 0x00.
- R3: In test mode (mode 110), a write to the data address (select 2'b00) appends a byte to the FIFO. A read strobe there removes the oldest byte. The data address always shows the oldest byte in first-in, first-out order.
- R4: A write to a full FIFO (DEPTH bytes held) is dropped. The data address reads 0x00 when the FIFO is empty. A read strobe on an empty FIFO changes nothing.
- R5: Outside test mode, writes to the data address are ignored, reads of it return 0x00, and read strobes there do not remove data.
- R6: With `dir_i` = 1, in any mode other than 000 and 001, the service bit goes from 0 to 1 on the clock edge after the registered fill level is at least RD_THR.
- R7: With `dir_i` = 0, in any mode other than 000 and 001, the service bit goes from 0 to 1 on the clock edge after the free space (DEPTH minus fill level) is at least WR_THR.
- R8: `irq_o` rises together with a hardware setting of the service bit and stays high until the next control-register write. While the service bit holds 1 because software wrote it, no further service event or interrupt occurs. A control-register write takes priority over a hardware setting in the same cycle.
- R9: A control-register write whose mode field is 000 or 001 empties the FIFO. A write with any other mode keeps its contents.
- R10: Select code 2'b01 reads the configuration word 0x10 (bits 6:4 = 001, meaning an 8-bit word). Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Register select: 00 data FIFO, 01 configuration word, 10 control register |
| wr_en_i | input | 1 | Host write strobe, one cycle per access |
| rd_en_i | input | 1 | Host read strobe, one cycle per access |
| wdata_i | input | 8 | Host write data |
| dir_i | input | 1 | Transfer direction: 1 fill threshold, 0 drain threshold |
| rdata_o | output | 8 | Read data of the selected register, combinational |
| irq_o | output | 1 | Service interrupt request |

## Verification
`rdata_o` is a combinational view of registered state. It is valid in the same cycle as the select. A strobe's effect on the FIFO or the control register shows in the cycle after the edge that takes it. The service bit and `irq_o` move one further edge later, because the threshold compare looks at the registered fill level. The bench drives inputs on the falling edge and samples one nanosecond later. Its queue-based model is advanced right after each rising edge, so every expected value already includes this extra edge. The threshold and interrupt checks therefore fall in exactly the cycle in which the design should respond.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

   // host register select codes
   localparam logic [1:0] SEL_DATA = 2'b00;
   localparam logic [1:0] SEL_CFGA = 2'b01;
   localparam logic [1:0] SEL_CTL  = 2'b10;

   // operating mode codes (control bits 7:5)
   localparam logic [2:0] MD_STD  = 3'b000;
   localparam logic [2:0] MD_BYTE = 3'b001;
   localparam logic [2:0] MD_TEST = 3'b110;

   // stored control bits 7:2 at reset: mode 000, fault off, no DMA, service 1
   localparam logic [5:0] CTL_RST = 6'b000101;

   // configuration word: 8-bit port word size code in bits 6:4
   localparam logic [7:0] CFGA_WORD8 = 8'h10;

endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic          flush_i,
   input  logic [W-1:0]  wdata_i,
   output logic [W-1:0]  head_o,
   output logic [CW-1:0] count_o,
   output logic          empty_o,
   output logic          full_o
);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, nxt_wr, nxt_rd;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   initial begin
      assert (DEPTH >= 2) else $error("pfq_store: DEPTH must be at least 2");
      assert (W >= 1) else $error("pfq_store: W must be positive");
   end

   assign empty_o = (cnt == '0);
   assign full_o  = (cnt == CW'(DEPTH));
   assign do_push = push_i & ~full_o;
   assign do_pop  = pop_i & ~empty_o;

   // pointer advance: free wrap for power-of-two depth, compare otherwise
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign nxt_wr = wr_ptr + 1'b1;
         assign nxt_rd = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign nxt_wr = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign nxt_rd = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (flush_i) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= nxt_wr;
         if (do_pop)  rd_ptr <= nxt_rd;
         unique case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!flush_i && do_push) mem[wr_ptr] <= wdata_i;
   end

   assign head_o  = mem[rd_ptr];
   assign count_o = cnt;

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && push_i && !pop_i && !flush_i) |=> (count_o == CW'(DEPTH)));

   // R4
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && pop_i && !push_i && !flush_i) |=> empty_o);

   // R9
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> empty_o);

endmodule

// File: rtl/pfq_ecr.sv
module pfq_ecr
   import pfq_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int RD_THR = DEPTH / 2,
   parameter int WR_THR = DEPTH / 2,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [7:0]    wdata_i,
   input  logic          dir_i,
   input  logic [CW-1:0] count_i,
   output logic [5:0]    ctl_o,
   output logic          flush_o,
   output logic          irq_o
);

   logic [5:0] ctl_q;
   logic       irq_q;
   logic [2:0] mode;
   logic       svc, fifo_md, lvl_hit, hw_set;

   initial begin
      assert (RD_THR >= 1 && RD_THR <= DEPTH) else $error("pfq_ecr: RD_THR out of range");
      assert (WR_THR >= 1 && WR_THR <= DEPTH) else $error("pfq_ecr: WR_THR out of range");
   end

   assign mode    = ctl_q[5:3];
   assign svc     = ctl_q[0];
   assign fifo_md = mode[2] | mode[1];
   assign lvl_hit = dir_i ? (count_i >= CW'(RD_THR))
                          : ((CW'(DEPTH) - count_i) >= CW'(WR_THR));
   assign hw_set  = fifo_md & ~svc & lvl_hit;
   assign flush_o = wr_i & (wdata_i[7:6] == 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RST;
         irq_q <= 1'b0;
      end else if (wr_i) begin
         ctl_q <= wdata_i[7:2];
         irq_q <= 1'b0;
      end else if (hw_set) begin
         ctl_q[0] <= 1'b1;
         irq_q    <= 1'b1;
      end
   end

   assign ctl_o = ctl_q;
   assign irq_o = irq_q;

   // R8
   irq_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(!svc));

   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !wr_i) |=> irq_o);

   // R8
   irq_sets_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> svc);

endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
   import pfq_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int RD_THR = DEPTH / 2,
   parameter int WR_THR = DEPTH / 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel_i,
   input  logic       wr_en_i,
   input  logic       rd_en_i,
   input  logic [7:0] wdata_i,
   input  logic       dir_i,
   output logic [7:0] rdata_o,
   output logic       irq_o
);

   localparam int CW = $clog2(DEPTH + 1);

   logic [5:0]    ctl;
   logic [7:0]    head;
   logic [CW-1:0] count;
   logic          empty, full, flush, test_md, wr_ctl, push, pop;

   assign test_md = (ctl[5:3] == MD_TEST);
   assign wr_ctl  = wr_en_i & (sel_i == SEL_CTL);
   assign push    = wr_en_i & (sel_i == SEL_DATA) & test_md;
   assign pop     = rd_en_i & (sel_i == SEL_DATA) & test_md;

   pfq_ecr #(.DEPTH(DEPTH), .RD_THR(RD_THR), .WR_THR(WR_THR)) u_ecr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_ctl),
      .wdata_i (wdata_i),
      .dir_i   (dir_i),
      .count_i (count),
      .ctl_o   (ctl),
      .flush_o (flush),
      .irq_o   (irq_o)
   );

   pfq_store #(.DEPTH(DEPTH), .W(8)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .pop_i   (pop),
      .flush_i (flush),
      .wdata_i (wdata_i),
      .head_o  (head),
      .count_o (count),
      .empty_o (empty),
      .full_o  (full)
   );

   always_comb begin
      unique case (sel_i)
         SEL_DATA: rdata_o = (test_md && !empty) ? head : 8'h00;
         SEL_CFGA: rdata_o = CFGA_WORD8;
         SEL_CTL:  rdata_o = {ctl, full, empty};
         default:  rdata_o = 8'h00;
      endcase
   end

   // R5
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == SEL_DATA && !test_md) |-> (rdata_o == 8'h00));

   // R5
   idle_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_md && !flush) |=> $stable(count));

endmodule

// File: tb/pfq_ctrl_tb.sv
module pfq_ctrl_tb;

   localparam int DEPTH = 16;
   localparam int RDT   = 8;
   localparam int WRT   = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel = 2'b10;
   logic       wr_en = 1'b0, rd_en = 1'b0, dir = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq;

   always #5 clk = ~clk;

   pfq_ctrl #(.DEPTH(DEPTH), .RD_THR(RDT), .WR_THR(WRT)) u_dut (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .wdata_i(wdata), .dir_i(dir), .rdata_o(rdata), .irq_o(irq)
   );

   int  vecs = 0;
   int  errs = 0;
   bit  done = 1'b0;

   // behavioural reference
   logic [7:0] q[$];
   logic [5:0] m_ctl = 6'b000101;
   logic       m_irq = 1'b0;

   function automatic logic [7:0] exp_rd(input logic [1:0] s);
      logic [7:0] v;
      case (s)
         2'b00: v = (m_ctl[5:3] == 3'b110 && q.size() > 0) ? q[0] : 8'h00;
         2'b01: v = 8'h10;
         2'b10: v = {m_ctl, (q.size() == DEPTH), (q.size() == 0)};
         default: v = 8'h00;
      endcase
      return v;
   endfunction

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_step(input logic w, input logic r, input logic [1:0] s, input logic [7:0] d);
      logic [2:0] md = m_ctl[5:3];
      bit fm  = md[2] | md[1];
      bit hit = dir ? (q.size() >= RDT) : ((DEPTH - q.size()) >= WRT);
      if (w && s == 2'b10) begin
         m_ctl = d[7:2];
         m_irq = 1'b0;
         if (d[7:6] == 2'b00) q.delete();
      end else if (fm && !m_ctl[0] && hit) begin
         m_ctl[0] = 1'b1;
         m_irq    = 1'b1;
      end
      if (md == 3'b110) begin
         if (w && s == 2'b00 && q.size() < DEPTH) q.push_back(d);
         if (r && s == 2'b00 && q.size() > 0) void'(q.pop_front());
      end
   endtask

   task automatic cyc(input logic w, input logic r, input logic [1:0] s, input logic [7:0] d, input string tag);
      @(negedge clk);
      wr_en = w; rd_en = r; sel = s; wdata = d;
      #1;
      chk(tag, "rdata", rdata, exp_rd(s));
      chk("R8", "irq", {7'b0, irq}, {7'b0, m_irq});
      @(posedge clk);
      model_step(w, r, s, d);
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d, input string tag);
      cyc(1'b1, 1'b0, s, d, tag);
   endtask
   task automatic rd(input logic [1:0] s, input string tag);
      cyc(1'b0, 1'b1, s, 8'h00, tag);
   endtask
   task automatic idle(input string tag);
      cyc(1'b0, 1'b0, 2'b10, 8'h00, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errs++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", "ctl after reset", rdata, 8'h15);
      chk("R1", "irq after reset", {7'b0, irq}, 8'h00);
      idle("R1");
      cyc(1'b0, 1'b0, 2'b01, 8'h00, "R10");
      cyc(1'b0, 1'b0, 2'b11, 8'h00, "R2");

      // R2 byte mode, interrupts off
      wr(2'b10, 8'h34, "R2");
      idle("R2");

      // R5 data access outside test mode
      wr(2'b00, 8'hAA, "R5");
      rd(2'b00, "R5");
      idle("R5");

      // R10 configuration word is read-only
      wr(2'b01, 8'hFF, "R10");
      cyc(1'b0, 1'b0, 2'b01, 8'h00, "R10");

      // fill in test mode, direction 1
      dir = 1'b1;
      wr(2'b10, 8'hD4, "R2");
      wr(2'b10, 8'hD0, "R6");
      for (int i = 0; i < 20; i++) wr(2'b00, 8'h40 + 8'(i), (i < 16) ? "R3" : "R4");
      idle("R6");
      idle("R4");

      // drain, direction 0; mode rewrite keeps data
      dir = 1'b0;
      wr(2'b10, 8'hD4, "R9");
      idle("R9");
      wr(2'b10, 8'hD0, "R7");
      for (int i = 0; i < 19; i++) rd(2'b00, (i < 16) ? "R3" : "R4");
      idle("R7");
      cyc(1'b0, 1'b0, 2'b00, 8'h00, "R4");

      // masked service: software-written 1 blocks events
      wr(2'b10, 8'hD4, "R8");
      for (int i = 0; i < 4; i++) idle("R8");
      wr(2'b10, 8'hD0, "R8");
      idle("R8");
      idle("R8");

      // flush on byte mode and on standard mode
      dir = 1'b1;
      wr(2'b10, 8'hD4, "R9");
      for (int i = 0; i < 5; i++) wr(2'b00, 8'h90 + 8'(i), "R3");
      cyc(1'b0, 1'b0, 2'b00, 8'h00, "R3");
      wr(2'b10, 8'h34, "R9");
      idle("R9");
      wr(2'b10, 8'hD4, "R9");
      cyc(1'b0, 1'b0, 2'b00, 8'h00, "R9");
      for (int i = 0; i < 3; i++) wr(2'b00, 8'hC0 + 8'(i), "R3");
      wr(2'b10, 8'h14, "R9");
      idle("R9");
      wr(2'b10, 8'hD4, "R9");
      cyc(1'b0, 1'b0, 2'b00, 8'h00, "R9");
      idle("R2");

      finish_run();
   end

endmodule